// File: doc/BRIEF.md
# Two-Phase ZQ Calibration Scheduler

This block runs runtime impedance calibration on an LPDDR4-style memory while the controller carries on with normal work. A periodic trigger starts one calibration. Each calibration takes two slots on the command bus. The first is a calibration-start command. After a settling interval of at least 1 µs, the second is a calibration-latch command. Both are sent as a multipurpose command whose 7-bit operand rides on the low address bits.

The block asks the controller's command arbiter for each slot with a request/grant handshake. It drops its request as soon as the start command has gone out, so reads, writes and refreshes keep the bus during the long settling interval. After the latch it waits out a lockout of at least 8 cycles and at least 30 ns. It then pulses a completion flag. A busy flag covers the whole calibration, so the controller can hold off power-down or self-refresh entry.

The interval lengths come from a clock-frequency parameter and are rounded up to whole cycles. With the defaults (250 MHz), the settling interval `CAL_CYC` is 250 cycles and the lockout `LAT_CYC` is 8 cycles.

Top module: `zqcal_sched`

## Requirements
- R1: After a one-cycle trigger pulse in the idle state, `req_o` and `busy_o` are high in the next cycle.
- R2: In the cycle where the start slot is granted (`req_o` and `gnt_i` both high), the outputs carry a multipurpose command: cs_n=0, ras_n=1, cas_n=1, we_n=0, bank=0, address[6:0]=7'b1001111, and all higher address bits 0.
- R3: In the cycle where the latch slot is granted, the outputs carry the same multipurpose encoding with address[6:0]=7'b1010001, higher address bits 0 and bank 0.
- R4: The latch command issues no fewer than CAL_CYC = ceil(CAL_NS·CLK_MHZ/1000) cycles after the start command. The latch request rises exactly CAL_CYC cycles after the start issue, so with a grant that waits G cycles the gap is CAL_CYC+G.
- R5: `req_o` is low from the cycle after the start issue until the latch request rises, so the command bus is free during that time.
- R6: `done_o` is a single-cycle pulse exactly LAT_CYC = max(LAT_MIN_CK, ceil(LAT_NS·CLK_MHZ/1000)) cycles after the latch issue.
- R7: In every cycle without a granted request, cs_n, ras_n, cas_n and we_n are all 1 and bank and address are 0. A grant with no request outstanding is ignored.
- R8: Any number of triggers during a calibration collapse into one pending calibration. Its start request rises in the cycle after `done_o`, and no further calibration follows.
- R9: `busy_o` is high whenever `req_o` is high and through both waits, and it is low in the `done_o` cycle.
- R10: During and right after reset, `req_o`, `busy_o` and `done_o` are 0 and the command outputs show deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Periodic calibration trigger |
| gnt_i | input | 1 | Slot grant from the command arbiter |
| req_o | output | 1 | Slot request to the command arbiter |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| bank_o | output | BANK_W | Bank address |
| addr_o | output | ADDR_W | Address, operand in bits [6:0] |

## Verification
The block is driven three ways.
- An immediate grant pins the start-to-latch gap at exactly CAL_CYC, which exposes an off-by-one in the settling count.
- A grant delayed by several cycles shows that the command appears only in the granted cycle and that the idle encoding holds while the request waits.
- A burst of triggers inside a running calibration, under a short grant delay, separates correct merging into one pending calibration from dropped or stacked triggers.

Grants forced high while idle show that an unrequested grant leaves the bus deselected.

// File: rtl/zqcal_pkg.sv
package zqcal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_REQ_START = 3'd1,
    ST_WAIT_CAL  = 3'd2,
    ST_REQ_LATCH = 3'd3,
    ST_WAIT_LAT  = 3'd4,
    ST_DONE      = 3'd5
  } zq_state_t;

  localparam logic [6:0] OP_ZQ_START = 7'b1001111;
  localparam logic [6:0] OP_ZQ_LATCH = 7'b1010001;

  // nanoseconds to whole cycles, rounded up
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/zqcal_timer.sv
module zqcal_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         exp_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  // last counted cycle: the owner moves on at the next edge
  assign exp_o = (cnt_q == W'(1));
endmodule

// File: rtl/zqcal_fsm.sv
module zqcal_fsm
  import zqcal_pkg::*;
#(
  parameter int unsigned W      = 8,
  parameter int unsigned CAL_LD = 249,
  parameter int unsigned LAT_LD = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         trig_i,
  input  logic         gnt_i,
  input  logic         tmr_exp_i,
  output logic         req_o,
  output logic         sel_latch_o,
  output logic         busy_o,
  output logic         done_o,
  output logic         ev_start_o,
  output logic         ev_latch_o,
  output logic         tmr_load_o,
  output logic [W-1:0] tmr_val_o
);
  zq_state_t st_q, st_d;
  logic      pend_q;

  assign req_o       = (st_q == ST_REQ_START) || (st_q == ST_REQ_LATCH);
  assign sel_latch_o = (st_q == ST_REQ_LATCH);
  assign ev_start_o  = (st_q == ST_REQ_START) && gnt_i;
  assign ev_latch_o  = (st_q == ST_REQ_LATCH) && gnt_i;
  assign busy_o      = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign done_o      = (st_q == ST_DONE);
  assign tmr_load_o  = ev_start_o || ev_latch_o;
  assign tmr_val_o   = ev_latch_o ? W'(LAT_LD) : W'(CAL_LD);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:      if (trig_i)    st_d = ST_REQ_START;
      ST_REQ_START: if (gnt_i)     st_d = ST_WAIT_CAL;
      ST_WAIT_CAL:  if (tmr_exp_i) st_d = ST_REQ_LATCH;
      ST_REQ_LATCH: if (gnt_i)     st_d = ST_WAIT_LAT;
      ST_WAIT_LAT:  if (tmr_exp_i) st_d = ST_DONE;
      ST_DONE:      st_d = (pend_q || trig_i) ? ST_REQ_START : ST_IDLE;
      default:      st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_DONE)      pend_q <= 1'b0;
      else if (busy_o && trig_i) pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/zqcal_cmd_enc.sv
module zqcal_cmd_enc
  import zqcal_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned BANK_W = 3
) (
  input  logic              fire_i,
  input  logic              sel_latch_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [6:0] op;
  assign op      = sel_latch_i ? OP_ZQ_LATCH : OP_ZQ_START;
  assign cs_n_o  = !fire_i;
  assign ras_n_o = 1'b1;
  assign cas_n_o = 1'b1;
  assign we_n_o  = !fire_i;
  assign bank_o  = '0;
  assign addr_o  = fire_i ? {{(ADDR_W-7){1'b0}}, op} : '0;
endmodule

// File: rtl/zqcal_sched.sv
module zqcal_sched
  import zqcal_pkg::*;
#(
  parameter int unsigned CLK_MHZ    = 250,
  parameter int unsigned CAL_NS     = 1000,
  parameter int unsigned LAT_NS     = 30,
  parameter int unsigned LAT_MIN_CK = 8,
  parameter int unsigned ADDR_W     = 17,
  parameter int unsigned BANK_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic              gnt_i,
  output logic              req_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned CAL_CYC = umax(2, ns2cyc(CAL_NS, CLK_MHZ));
  localparam int unsigned LAT_CYC = umax(2, umax(LAT_MIN_CK, ns2cyc(LAT_NS, CLK_MHZ)));
  localparam int unsigned TMR_W   = $clog2(umax(CAL_CYC, LAT_CYC) + 1);

  // named internal events, also watched by the checker
  logic             ev_start, ev_latch, fire, sel_latch;
  logic             tmr_load, tmr_exp;
  logic [TMR_W-1:0] tmr_val;

  zqcal_fsm #(.W(TMR_W), .CAL_LD(CAL_CYC - 1), .LAT_LD(LAT_CYC - 1)) i_fsm (
    .clk, .rst_n, .trig_i, .gnt_i,
    .tmr_exp_i(tmr_exp), .req_o, .sel_latch_o(sel_latch), .busy_o, .done_o,
    .ev_start_o(ev_start), .ev_latch_o(ev_latch),
    .tmr_load_o(tmr_load), .tmr_val_o(tmr_val)
  );

  zqcal_timer #(.W(TMR_W)) i_timer (
    .clk, .rst_n, .load_i(tmr_load), .val_i(tmr_val), .exp_o(tmr_exp)
  );

  assign fire = ev_start || ev_latch;

  zqcal_cmd_enc #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) i_enc (
    .fire_i(fire), .sel_latch_i(sel_latch),
    .cs_n_o, .ras_n_o, .cas_n_o, .we_n_o, .bank_o, .addr_o
  );
endmodule

// File: rtl/zqcal_sched_chk.sv
module zqcal_sched_chk
  import zqcal_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 250,
  parameter int unsigned CAL_NS  = 1000,
  parameter int unsigned ADDR_W  = 17,
  parameter int unsigned BANK_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gnt_i,
  input logic              req_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              cs_n_o,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic              we_n_o,
  input logic [BANK_W-1:0] bank_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              ev_start,
  input logic              ev_latch
);
  localparam int unsigned CAL_CYC = umax(2, ns2cyc(CAL_NS, CLK_MHZ));

  int unsigned gap_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                gap_q <= 0;
    else if (ev_start)         gap_q <= 1;
    else if (gap_q != 0 && gap_q < CAL_CYC + 4) gap_q <= gap_q + 1;
  end

  p_grant_drives_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && gnt_i) |-> (!cs_n_o && ras_n_o && cas_n_o && !we_n_o && bank_o == '0));
  p_start_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |-> addr_o == ADDR_W'(OP_ZQ_START));
  p_latch_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_latch |-> addr_o == ADDR_W'(OP_ZQ_LATCH));
  p_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_latch |-> gap_q >= CAL_CYC);
  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !req_o);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_idle_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> (ras_n_o && cas_n_o && we_n_o && bank_o == '0 && addr_o == '0));
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !gnt_i) |=> req_o);
  p_busy_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> busy_o);
  p_busy_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
endmodule

bind zqcal_sched zqcal_sched_chk #(
  .CLK_MHZ(CLK_MHZ), .CAL_NS(CAL_NS), .ADDR_W(ADDR_W), .BANK_W(BANK_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .gnt_i(gnt_i), .req_o(req_o), .busy_o(busy_o),
  .done_o(done_o), .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
  .we_n_o(we_n_o), .bank_o(bank_o), .addr_o(addr_o),
  .ev_start(ev_start), .ev_latch(ev_latch)
);

// File: tb/test_zqcal_sched.sv
module test_zqcal_sched;
  localparam int ADDR_W = 17;
  localparam int BANK_W = 3;
  // expected windows, restated from the requirements at 250 MHz
  localparam int CAL_EXP = (1000 * 250 + 999) / 1000;
  localparam int LAT_RAW = (30 * 250 + 999) / 1000;
  localparam int LAT_EXP = (LAT_RAW > 8) ? LAT_RAW : 8;
  localparam logic [6:0] OPS = 7'b1001111;
  localparam logic [6:0] OPL = 7'b1010001;

  logic clk = 1'b0, rst_n = 1'b0, trig_i = 1'b0, gnt_i = 1'b0;
  logic req_o, busy_o, done_o, cs_n_o, ras_n_o, cas_n_o, we_n_o;
  logic [BANK_W-1:0] bank_o;
  logic [ADDR_W-1:0] addr_o;

  zqcal_sched i_zqcal_sched (
    .clk, .rst_n, .trig_i, .gnt_i, .req_o, .busy_o, .done_o,
    .cs_n_o, .ras_n_o, .cas_n_o, .we_n_o, .bank_o, .addr_o
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int gnt_delay = 0, req_age = 0;
  logic force_gnt = 1'b0;
  logic [6:0] exp_q[$];
  int start_cyc = -1, latch_cyc = -1, done_cyc = -1, req_rise_cyc = -1;
  int n_done = 0;
  logic prev_req = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // driver side of the scoreboard: one calibration = start then latch
  task automatic expect_cal();
    exp_q.push_back(OPS);
    exp_q.push_back(OPL);
  endtask

  task automatic pulse_trig();
    trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
  endtask

  task automatic wait_done(input int n);
    int lim = 0;
    while (n_done < n && lim < 5000) begin
      @(negedge clk);
      lim++;
    end
    chk(n_done >= n, "R6 done count", n_done, n);
  endtask

  // arbiter model and monitor: grant at negedge, sample 1 ns later
  always @(negedge clk) begin
    gnt_i = force_gnt || (req_o && req_age >= gnt_delay);
    #1;
    if (rst_n) begin
      if (req_o && !prev_req) req_rise_cyc = cyc;
      prev_req = req_o;
      if (req_o) chk(busy_o, "R9 busy with req", busy_o, 1);
      if (!cs_n_o) begin
        logic [6:0] e;
        chk(exp_q.size() != 0, "R7 unexpected command", 1, 0);
        e = (exp_q.size() != 0) ? exp_q.pop_front() : 7'h7f;
        chk(req_o && gnt_i, "R7 cmd only when granted", int'(req_o && gnt_i), 1);
        chk({ras_n_o, cas_n_o, we_n_o} == 3'b110 && bank_o == '0,
            "R2 mpc encoding", int'({ras_n_o, cas_n_o, we_n_o}), 6);
        chk(addr_o == ADDR_W'(e), (e == OPS) ? "R2 start operand" : "R3 latch operand",
            int'(addr_o), int'(e));
        if (e == OPS) start_cyc = cyc;
        else begin
          latch_cyc = cyc;
          chk(cyc - start_cyc == CAL_EXP + gnt_delay, "R4 start-latch gap",
              cyc - start_cyc, CAL_EXP + gnt_delay);
        end
      end else if (!(ras_n_o && cas_n_o && we_n_o && bank_o == '0 && addr_o == '0)) begin
        chk(1'b0, "R7 idle bus", int'(addr_o), 0);
      end
      if (done_o) begin
        n_done++;
        done_cyc = cyc;
        chk(cyc - latch_cyc == LAT_EXP, "R6 lockout length", cyc - latch_cyc, LAT_EXP);
        chk(!busy_o, "R9 busy low at done", busy_o, 0);
      end
      if (req_o && !gnt_i) req_age++;
      else req_age = 0;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!req_o && !busy_o && !done_o, "R10 reset flags", int'({req_o, busy_o, done_o}), 0);
    chk(cs_n_o && addr_o == '0, "R10 reset bus", int'(cs_n_o), 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // immediate grant: exact settling gap
    gnt_delay = 0;
    expect_cal();
    pulse_trig();
    #1;
    chk(req_o && busy_o, "R1 request after trigger", int'({req_o, busy_o}), 3);
    repeat (100) @(negedge clk);
    #1;
    chk(!req_o && cs_n_o, "R5 bus released mid-wait", int'(req_o), 0);
    chk(busy_o, "R9 busy mid-wait", busy_o, 1);
    wait_done(1);
    repeat (3) @(negedge clk);
    #1;
    chk(!busy_o && !req_o, "R9 idle after calibration", int'({busy_o, req_o}), 0);

    // delayed grant
    gnt_delay = 5;
    expect_cal();
    pulse_trig();
    wait_done(2);
    repeat (3) @(negedge clk);

    // triggers during calibration merge into one pending
    gnt_delay = 2;
    expect_cal();
    expect_cal();
    pulse_trig();
    repeat (20) @(negedge clk);
    pulse_trig();
    repeat (30) @(negedge clk);
    pulse_trig();
    wait_done(3);
    @(negedge clk);
    #1;
    chk(req_rise_cyc == done_cyc + 1, "R8 pending served after done", req_rise_cyc, done_cyc + 1);
    wait_done(4);
    repeat (400) @(negedge clk);
    chk(n_done == 4 && exp_q.size() == 0, "R8 no extra calibration", n_done, 4);

    // grant without request is ignored
    force_gnt = 1'b1;
    repeat (10) @(negedge clk);
    #1;
    chk(cs_n_o && !req_o, "R7 unrequested grant ignored", int'(cs_n_o), 1);
    force_gnt = 1'b0;
    repeat (2) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule